// File: doc/BRIEF.md
# Bridge I/O Window Decoder with Secondary Error Status

This block is a register slice of a virtual PCI-to-PCI bridge. It holds two 4-bit programmable fields, an I/O window base and an I/O window limit. For each processor I/O address it decides whether the access falls inside the window and must be forwarded to the downstream link. The fields cover address bits 15:12. The low twelve bits are taken as 000h at the base and FFFh at the limit, so the window always spans whole 4 KB blocks.

The block also keeps a 16-bit secondary status word with three sticky error flags. Single-cycle strobes from the downstream side set the flags:

- a poisoned TLP was received;
- a fatal or non-fatal error message arrived;
- an Unsupported Request completion came back for a request the bridge issued itself.

Software clears a flag by writing a one to its bit. Configuration access uses a plain byte-enabled port with a one-bit word select. Reads are combinational. Writes take effect at the next clock edge.

Address decode is a stream. The request side is `io_req_valid`/`io_req_ready`. The response side is `io_rsp_valid`/`io_rsp_ready`, and it carries the forward decision. A request is accepted on a rising edge where both valid and ready are high. `io_req_ready` is high whenever the response slot is empty or is being drained in the same cycle. A response stays valid, with its decision unchanged, until it is taken.

Top module: `vbr_iowin_status`

## Requirements
- R1: After reset, word 0 (window) and word 1 (status) both read 0000h, and `io_rsp_valid` is low.
- R2: Word 0 is read when `cfg_sel`=0. Byte lane 0 (bits 7:0) is the base register and byte lane 1 (bits 15:8) is the limit register. Only bits 7:4 of each byte are written, and only when that lane's byte enable is set. Bits 3:0 of each byte read zero.
- R3: An address is forwarded (`io_rsp_fwd`=1) exactly when base×1000h ≤ address ≤ limit×1000h + FFFh. In other words, address bits 15:12 lie between the base and limit nibbles, both ends included.
- R4: When the base nibble is greater than the limit nibble, no address is forwarded.
- R5: A response is due one cycle after acceptance. While `io_rsp_ready` is low, the response stays valid with a stable decision, and `io_req_ready` is low.
- R6: A pulse on `ev_poisoned_tlp` sets status bit 15 on the next edge. There is no enable that can gate it.
- R7: A pulse on `ev_err_msg` sets status bit 14 on the next edge.
- R8: A pulse on `ev_ur_cpl_self` sets status bit 13 on the next edge.
- R9: Word 1 is read when `cfg_sel`=1. Writing a one to bit 13, 14 or 15 with byte enable 1 set clears that bit. Writing zeros, or writing with byte enable 1 clear, leaves the bits unchanged.
- R10: When a set event and a clearing write hit the same bit in the same cycle, the bit ends set.
- R11: Status bits 12:0 always read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Word select: 0 = window, 1 = status |
| cfg_be | input | 2 | Byte enables for the write |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Combinational read data of the selected word |
| io_req_valid | input | 1 | I/O address request valid |
| io_req_ready | output | 1 | Block can accept a request |
| io_req_addr | input | 16 | Processor I/O address |
| io_rsp_valid | output | 1 | Decision valid |
| io_rsp_ready | input | 1 | Consumer takes the decision |
| io_rsp_fwd | output | 1 | 1 = forward downstream |
| ev_poisoned_tlp | input | 1 | Poisoned TLP received |
| ev_err_msg | input | 1 | Fatal or non-fatal error message received |
| ev_ur_cpl_self | input | 1 | UR completion for the bridge's own request |

## Verification
A decision is due one cycle after its request is accepted. The scoreboard queues the expected decision at the accepting edge and compares it when the response handshake is seen, so a stalled consumer only delays the comparison. Configuration writes and event strobes take effect at the next rising edge. The bench drives them just after one edge and reads the combinational read data at the falling edge that follows the capturing edge.

// File: rtl/vbr_iowin_pkg.sv
package vbr_iowin_pkg;
  localparam int ADDR_W  = 16;
  localparam int NIB_W   = 4;
  localparam int CFG_W   = 16;
  localparam int LANES   = CFG_W / 8;
  localparam int NUM_EV  = 3;
  localparam int EV_LSB  = 13;   // status bits EV_LSB .. EV_LSB+NUM_EV-1
  localparam int PAGE_LSB = ADDR_W - NIB_W;

  // event vector order: [2] poisoned TLP -> bit 15, [1] error msg -> bit 14,
  // [0] own UR completion -> bit 13
  typedef struct packed {
    logic poison;
    logic err_msg;
    logic ur_self;
  } sts_ev_t;
endpackage

// File: rtl/vbr_win_regs.sv
module vbr_win_regs
  import vbr_iowin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  be,
  input  logic [CFG_W-1:0]  wdata,
  output logic [NIB_W-1:0]  base_nib,
  output logic [NIB_W-1:0]  limit_nib
);
  localparam int NIB_OFS = 8 - NIB_W;

  logic [NIB_W-1:0] nib_q [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) nib_q[g] <= '0;
      else if (wr_en && be[g]) nib_q[g] <= wdata[g*8+NIB_OFS +: NIB_W];
    end

    AST_NIB_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && be[g]) |=> nib_q[g] == $past(wdata[g*8+NIB_OFS +: NIB_W])); // R2
    AST_NIB_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && be[g]) |=> $stable(nib_q[g])); // R2
  end

  assign base_nib  = nib_q[0];
  assign limit_nib = nib_q[1];
endmodule

// File: rtl/vbr_win_decode.sv
module vbr_win_decode
  import vbr_iowin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  base_nib,
  input  logic [NIB_W-1:0]  limit_nib,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fwd
);
  logic [NIB_W-1:0] page;
  logic             hit, accept, vld_q, fwd_q;

  assign page   = req_addr[PAGE_LSB +: NIB_W];
  // low bits implied 000h at base and FFFh at limit: page compare is exact
  assign hit    = (page >= base_nib) && (page <= limit_nib);
  assign req_ready = !vld_q || rsp_ready;
  assign accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      fwd_q <= 1'b0;
    end else if (accept) begin
      vld_q <= 1'b1;
      fwd_q <= hit;
    end else if (rsp_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_fwd   = fwd_q;

  AST_RSP_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid); // R5
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fwd))); // R5
  AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (base_nib > limit_nib)) |=> !rsp_fwd); // R4
endmodule

// File: rtl/vbr_sec_status.sv
module vbr_sec_status
  import vbr_iowin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  be,
  input  logic [CFG_W-1:0]  wdata,
  input  sts_ev_t           ev,
  output logic [CFG_W-1:0]  sts
);
  logic [NUM_EV-1:0] ev_v, bits_q, clr;

  assign ev_v = ev;

  for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
    localparam int POS = EV_LSB + i;
    assign clr[i] = wr_en && be[POS/8] && wdata[POS];

    always_ff @(posedge clk) begin
      if (!rst_n) bits_q[i] <= 1'b0;
      else        bits_q[i] <= ev_v[i] | (bits_q[i] & ~clr[i]);
    end

    AST_EV_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_v[i] |=> sts[POS]); // R6 R7 R8 R10
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !ev_v[i]) |=> !sts[POS]); // R9
    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr[i] && !ev_v[i]) |=> $stable(sts[POS])); // R9
  end

  assign sts = CFG_W'(bits_q) << EV_LSB;
endmodule

// File: rtl/vbr_iowin_status.sv
module vbr_iowin_status
  import vbr_iowin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [1:0]        cfg_be,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              io_req_valid,
  output logic              io_req_ready,
  input  logic [15:0]       io_req_addr,
  output logic              io_rsp_valid,
  input  logic              io_rsp_ready,
  output logic              io_rsp_fwd,
  input  logic              ev_poisoned_tlp,
  input  logic              ev_err_msg,
  input  logic              ev_ur_cpl_self
);
  localparam int PAD_W = 8 - NIB_W;

  logic [NIB_W-1:0] base_nib, limit_nib;
  logic [CFG_W-1:0] sts_word, win_word;
  sts_ev_t          ev;

  assign ev = '{poison: ev_poisoned_tlp, err_msg: ev_err_msg, ur_self: ev_ur_cpl_self};

  vbr_win_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr && !cfg_sel), .be(cfg_be),
    .wdata(cfg_wdata), .base_nib(base_nib), .limit_nib(limit_nib));

  vbr_win_decode u_dec (
    .clk(clk), .rst_n(rst_n), .base_nib(base_nib), .limit_nib(limit_nib),
    .req_valid(io_req_valid), .req_ready(io_req_ready), .req_addr(io_req_addr),
    .rsp_valid(io_rsp_valid), .rsp_ready(io_rsp_ready), .rsp_fwd(io_rsp_fwd));

  vbr_sec_status u_sts (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr && cfg_sel), .be(cfg_be),
    .wdata(cfg_wdata), .ev(ev), .sts(sts_word));

  assign win_word  = {limit_nib, PAD_W'(0), base_nib, PAD_W'(0)};
  assign cfg_rdata = cfg_sel ? sts_word : win_word;

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rsp_valid && !io_rsp_ready) |-> !io_req_ready); // R5
  AST_RSV_STS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel |-> (cfg_rdata[EV_LSB-1:0] == '0)); // R11
endmodule

// File: tb/vbr_iowin_status_bench.sv
`timescale 1ns/100ps
module vbr_iowin_status_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, cfg_sel = 0;
  logic [1:0] cfg_be = 0;
  logic [15:0] cfg_wdata = 0, cfg_rdata;
  logic io_req_valid = 0, io_req_ready, io_rsp_valid, io_rsp_ready = 1, io_rsp_fwd;
  logic [15:0] io_req_addr = 0;
  logic ev_poisoned_tlp = 0, ev_err_msg = 0, ev_ur_cpl_self = 0;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [3:0] m_base = 0, m_limit = 0;
  bit exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  vbr_iowin_status u_vbr_iowin_status (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // one cycle of config write and/or event strobes
  task automatic drive(bit wr, bit sel, logic [1:0] be, logic [15:0] d, logic [2:0] ev);
    @(posedge clk); #1;
    cfg_wr = wr; cfg_sel = sel; cfg_be = be; cfg_wdata = d;
    {ev_poisoned_tlp, ev_err_msg, ev_ur_cpl_self} = ev;
    @(posedge clk); #1;
    cfg_wr = 0; cfg_be = 0;
    {ev_poisoned_tlp, ev_err_msg, ev_ur_cpl_self} = 3'b000;
    if (wr && !sel) begin
      if (be[0]) m_base  = d[7:4];
      if (be[1]) m_limit = d[15:12];
    end
  endtask

  task automatic rd(bit sel, string req, logic [15:0] exp);
    @(negedge clk);
    cfg_sel = sel;
    #0.5;
    chk(req, cfg_rdata, exp);
  endtask

  // driver: push expected decision at acceptance
  task automatic io_req(logic [15:0] a, string req);
    @(posedge clk); #1;
    io_req_valid = 1; io_req_addr = a;
    forever begin
      @(negedge clk);
      if (io_req_ready) break;
    end
    exp_q.push_back((a[15:12] >= m_base) && (a[15:12] <= m_limit));
    tag_q.push_back(req);
    @(posedge clk); #1;
    io_req_valid = 0;
    @(negedge clk);
    chk({req, " R5 due"}, io_rsp_valid, 1);
  endtask

  // monitor: compare at each response handshake
  always @(negedge clk) begin
    if (rst_n && io_rsp_valid && io_rsp_ready) begin
      if (exp_q.size() == 0) chk("R5 unexpected response", 1, 0);
      else chk(tag_q.pop_front(), io_rsp_fwd, exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(0, "R1 window reset", 16'h0000);
    rd(1, "R1 status reset", 16'h0000);
    chk("R1 rsp idle", io_rsp_valid, 0);

    drive(1, 0, 2'b10, 16'h3FA5, 3'b000);
    rd(0, "R2 limit lane only", 16'h3000);
    drive(1, 0, 2'b01, 16'hFF2C, 3'b000);
    rd(0, "R2 base lane", 16'h3020);

    io_req(16'h2000, "R3 base edge");
    io_req(16'h1FFF, "R3 below base");
    io_req(16'h3FFF, "R3 limit edge");
    io_req(16'h4000, "R3 above limit");
    io_req(16'h2ABC, "R3 inside");

    drive(1, 0, 2'b11, 16'h3050, 3'b000);
    rd(0, "R2 both lanes", 16'h3050);
    io_req(16'h3000, "R4 empty window a");
    io_req(16'h5000, "R4 empty window b");
    io_req(16'h4123, "R4 empty window c");

    drive(1, 0, 2'b11, 16'hF000, 3'b000);
    io_rsp_ready = 0;
    io_req(16'hE123, "R5 stalled");
    @(negedge clk);
    chk("R5 req blocked", io_req_ready, 0);
    repeat (3) @(negedge clk);
    chk("R5 held valid", io_rsp_valid, 1);
    chk("R5 held fwd", io_rsp_fwd, 1);
    @(posedge clk); #1 io_rsp_ready = 1;
    @(posedge clk); #1;
    @(negedge clk);
    chk("R5 drained", io_rsp_valid, 0);

    drive(0, 1, 2'b00, 16'h0000, 3'b100);
    rd(1, "R6 poison", 16'h8000);
    drive(0, 1, 2'b00, 16'h0000, 3'b010);
    rd(1, "R7 err msg", 16'hC000);
    drive(0, 1, 2'b00, 16'h0000, 3'b001);
    rd(1, "R8 own UR", 16'hE000);

    drive(1, 1, 2'b10, 16'h4000, 3'b000);
    rd(1, "R9 clear bit14", 16'hA000);
    drive(1, 1, 2'b01, 16'hFFFF, 3'b000);
    rd(1, "R9 lane off no clear", 16'hA000);
    drive(1, 1, 2'b11, 16'h1FFF, 3'b000);
    rd(1, "R11 low bits ignored", 16'hA000);
    drive(1, 1, 2'b10, 16'h0000, 3'b000);
    rd(1, "R9 zeros keep", 16'hA000);

    drive(1, 1, 2'b10, 16'h8000, 3'b100);
    rd(1, "R10 set wins", 16'hA000);
    drive(1, 1, 2'b11, 16'hFFFF, 3'b000);
    rd(1, "R9 clear all", 16'h0000);
    rd(0, "R2 window untouched", 16'hF000);

    repeat (3) @(negedge clk);
    chk("R5 scoreboard empty", exp_q.size(), 0);
    done = 1;
    report();
  end
endmodule